// File: doc/BRIEF.md
# Core Sleep and Wake Controller

This block decides when a small processor core stops executing and when it starts again. The pipeline hands it one-cycle pulses for the wait-for-interrupt, wait-for-event and send-event instructions. A mode bit from a control register chooses a light nap or a deep sleep. In a light nap only the core clock is gated. In a deep sleep the system clock is gated as well, and power-down is requested for the PLL and the flash. The controller runs on an always-on clock. It registers every enable and request it drives, so the clock gates downstream see only clean, edge-aligned levels.

A hidden one-bit event flag makes wait-for-event conditional. The external event line, a send-event pulse, a pending interrupt or a debug wake request sets the flag. A wait-for-event that finds the flag set clears it and does not sleep. A wait-for-event that finds the flag clear sleeps. Leaving that sleep consumes the flag.

On leaving a deep sleep the controller first drops both power-down requests. It then holds the system clock gated until the PLL reports lock and the flash settling count has run out. Only after that does it release the core stall.

Top module: `sleep_ctrl_top`

## Requirements
- R1: After reset all five outputs are in the run pattern: core_clk_en=1, sys_clk_en=1, pll_pd_req=0, flash_pd_req=0, core_stall=0. The event flag is clear after reset, so the first wait-for-event sleeps.
- R2: In run, a wait-for-interrupt pulse with no wake source active stalls the core and gates the core clock from the next cycle on. Events do not end a wait-for-interrupt sleep.
- R3: In run, a wait-for-event pulse that finds the event flag clear enters sleep. While that sleep lasts, an external event or send-event pulse also ends it.
- R4: In run, a wait-for-event pulse that finds the event flag set does not stall the core and clears the flag, so the next wait-for-event sleeps.
- R5: An external event or send-event pulse in run sets the event flag, so the following wait-for-event does not sleep.
- R6: With the deep-sleep bit clear, sleep gates only the core clock: sys_clk_en stays 1 and both power-down requests stay 0.
- R7: With the deep-sleep bit set, sleep drives core_clk_en=0, sys_clk_en=0, pll_pd_req=1 and flash_pd_req=1.
- R8: A pending interrupt or a debug wake ends either kind of sleep. After a debug wake, a later wait instruction puts the core to sleep again.
- R9: On a deep-sleep wake the controller first drops both power-down requests while keeping sys_clk_en=0 and core_stall=1. It returns to run only at the first edge where the PLL-locked input is high and at least FLASH_WAKE_CYC cycles have passed since the wake.
- R10: A wait-for-interrupt that arrives while a wake source is already active holds the stall for exactly one cycle and then returns to run.
- R11: Wait-for-interrupt and wait-for-event pulses that arrive while the core is stalled have no effect. In particular they do not clear the event flag.
- R12: A pending interrupt or debug wake sets the event flag. Leaving a wait-for-interrupt sleep does not clear the flag; leaving a wait-for-event sleep does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_req | input | 1 | One-cycle wait-for-interrupt instruction pulse |
| wfe_req | input | 1 | One-cycle wait-for-event instruction pulse |
| sev_req | input | 1 | One-cycle send-event pulse |
| deep_sel | input | 1 | Sleep depth select: 0 nap, 1 deep |
| ext_evt | input | 1 | External event line |
| irq_pend | input | 1 | An interrupt is pending |
| dbg_wake | input | 1 | Debug wake request |
| pll_locked | input | 1 | PLL reports lock |
| core_clk_en | output | 1 | Core clock gate enable |
| sys_clk_en | output | 1 | System clock gate enable |
| pll_pd_req | output | 1 | PLL power-down request |
| flash_pd_req | output | 1 | Flash power-down request |
| core_stall | output | 1 | Holds the instruction pipeline |

## Verification
The bench checks the event flag only through its effect on a following wait-for-event. This exposes a design that forgets to set the flag on interrupts or debug wakes, or that wrongly clears it on a wait-for-interrupt exit or on a wait issued while stalled; such a design sleeps when it should fall through, or the reverse. Deep-sleep recovery is checked twice. In the first run the PLL lock comes late, which catches a design that ungates the system clock on the settling count alone. In the second run lock is present at once, which catches a design that is off by a cycle in the flash count. A wait-for-interrupt issued with an interrupt already pending must stall for exactly one cycle: a design that swallows the interrupt stays asleep, and one that skips the sleep never stalls.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_NAP     = 2'd1,
    ST_DEEP    = 2'd2,
    ST_RESTORE = 2'd3
  } pstate_t;

  typedef struct packed {
    logic core_en;
    logic sys_en;
    logic pll_pd;
    logic flash_pd;
    logic stall;
  } gate_t;

  // Output pattern for each state; registered by the gate stage.
  function automatic gate_t gate_of(pstate_t s);
    gate_t g;
    case (s)
      ST_RUN:     g = '{core_en: 1'b1, sys_en: 1'b1, pll_pd: 1'b0, flash_pd: 1'b0, stall: 1'b0};
      ST_NAP:     g = '{core_en: 1'b0, sys_en: 1'b1, pll_pd: 1'b0, flash_pd: 1'b0, stall: 1'b1};
      ST_DEEP:    g = '{core_en: 1'b0, sys_en: 1'b0, pll_pd: 1'b1, flash_pd: 1'b1, stall: 1'b1};
      default:    g = '{core_en: 1'b0, sys_en: 1'b0, pll_pd: 1'b0, flash_pd: 1'b0, stall: 1'b1};
    endcase
    return g;
  endfunction

  // Event flag update: consumption on wait-for-event exit wins,
  // then any new event, then the fall-through clear.
  function automatic logic evt_next(logic cur, logic set, logic skip, logic consume);
    if (consume)   return 1'b0;
    else if (set)  return 1'b1;
    else if (skip) return 1'b0;
    else           return cur;
  endfunction

  // Wake test for a sleeping core; events only count for wait-for-event sleeps.
  function automatic logic wake_hit(logic wfe_mode, logic irq, logic dbg, logic evt);
    return irq | dbg | (wfe_mode & evt);
  endfunction

endpackage

// File: rtl/sleep_evt_flag.sv
module sleep_evt_flag
  import sleep_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic skip_i,
  input  logic consume_i,
  output logic evt_o
);

  logic evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_next(evt_q, set_i, skip_i, consume_i);
  end

  assign evt_o = evt_q;

endmodule

// File: rtl/sleep_pwr_fsm.sv
module sleep_pwr_fsm
  import sleep_ctrl_pkg::*;
#(
  parameter int unsigned FLASH_WAKE_CYC = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wfi_i,
  input  logic    wfe_i,
  input  logic    deep_sel_i,
  input  logic    evt_q_i,
  input  logic    ext_evt_i,
  input  logic    sev_i,
  input  logic    irq_i,
  input  logic    dbg_i,
  input  logic    pll_locked_i,
  output pstate_t state_d_o,
  output logic    wfe_skip_o,
  output logic    wfe_exit_o,
  output logic    wake_o
);

  localparam int unsigned CW = $clog2(FLASH_WAKE_CYC + 1);

  pstate_t       state_q, state_d;
  logic          wfe_mode_q, wfe_mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run, sleeping, go_sleep, wfe_sleep, evt_any;

  assign run       = (state_q == ST_RUN);
  assign sleeping  = (state_q == ST_NAP) || (state_q == ST_DEEP);
  assign wfe_sleep = run && wfe_i && !wfi_i && !evt_q_i;
  assign go_sleep  = run && (wfi_i || wfe_sleep);
  assign evt_any   = evt_q_i | ext_evt_i | sev_i;
  assign wake_o    = wake_hit(wfe_mode_q, irq_i, dbg_i, evt_any);

  assign wfe_skip_o = run && wfe_i && !wfi_i && evt_q_i;
  assign wfe_exit_o = sleeping && wfe_mode_q && wake_o;

  always_comb begin
    state_d    = state_q;
    wfe_mode_d = wfe_mode_q;
    case (state_q)
      ST_RUN: begin
        if (go_sleep) begin
          state_d    = deep_sel_i ? ST_DEEP : ST_NAP;
          wfe_mode_d = wfe_sleep;
        end
      end
      ST_NAP:  if (wake_o) state_d = ST_RUN;
      ST_DEEP: if (wake_o) state_d = ST_RESTORE;
      default: if ((cnt_q == '0) && pll_locked_i) state_d = ST_RUN;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if ((state_q == ST_DEEP) && (state_d == ST_RESTORE))
      cnt_d = CW'(FLASH_WAKE_CYC);
    else if ((state_q == ST_RESTORE) && (cnt_q != '0))
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      wfe_mode_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      state_q    <= state_d;
      wfe_mode_q <= wfe_mode_d;
      cnt_q      <= cnt_d;
    end
  end

  assign state_d_o = state_d;

endmodule

// File: rtl/sleep_gate_reg.sv
module sleep_gate_reg
  import sleep_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_t state_d_i,
  output gate_t   gate_o
);

  gate_t gate_q;

  // Registered on the always-on edge so gate enables never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= gate_of(ST_RUN);
    else        gate_q <= gate_of(state_d_i);
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/sleep_ctrl_top.sv
module sleep_ctrl_top
  import sleep_ctrl_pkg::*;
#(
  parameter int unsigned FLASH_WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req,
  input  logic wfe_req,
  input  logic sev_req,
  input  logic deep_sel,
  input  logic ext_evt,
  input  logic irq_pend,
  input  logic dbg_wake,
  input  logic pll_locked,
  output logic core_clk_en,
  output logic sys_clk_en,
  output logic pll_pd_req,
  output logic flash_pd_req,
  output logic core_stall
);

  pstate_t state_d;
  gate_t   gate;
  logic    evt_q, evt_set, wfe_skip, wfe_exit, wake_now;

  assign evt_set = ext_evt | sev_req | irq_pend | dbg_wake;

  sleep_evt_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (evt_set),
    .skip_i    (wfe_skip),
    .consume_i (wfe_exit),
    .evt_o     (evt_q)
  );

  sleep_pwr_fsm #(.FLASH_WAKE_CYC(FLASH_WAKE_CYC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wfi_i        (wfi_req),
    .wfe_i        (wfe_req),
    .deep_sel_i   (deep_sel),
    .evt_q_i      (evt_q),
    .ext_evt_i    (ext_evt),
    .sev_i        (sev_req),
    .irq_i        (irq_pend),
    .dbg_i        (dbg_wake),
    .pll_locked_i (pll_locked),
    .state_d_o    (state_d),
    .wfe_skip_o   (wfe_skip),
    .wfe_exit_o   (wfe_exit),
    .wake_o       (wake_now)
  );

  sleep_gate_reg u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d_i (state_d),
    .gate_o    (gate)
  );

  assign core_clk_en  = gate.core_en;
  assign sys_clk_en   = gate.sys_en;
  assign pll_pd_req   = gate.pll_pd;
  assign flash_pd_req = gate.flash_pd;
  assign core_stall   = gate.stall;

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wfi_req,
  input logic sev_req,
  input logic deep_sel,
  input logic ext_evt,
  input logic irq_pend,
  input logic dbg_wake,
  input logic pll_locked,
  input logic core_clk_en,
  input logic sys_clk_en,
  input logic pll_pd_req,
  input logic flash_pd_req,
  input logic core_stall,
  input logic evt_q,
  input logic wfe_skip
);

  p_wfi_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stall && wfi_req && !irq_pend && !dbg_wake) |=> (core_stall && !core_clk_en));

  p_wfe_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wfe_skip |=> !core_stall);

  p_evt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stall && (ext_evt || sev_req)) |=> evt_q);

  p_nap_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stall && wfi_req && !deep_sel && !irq_pend && !dbg_wake)
      |=> (sys_clk_en && !pll_pd_req && !flash_pd_req));

  p_deep_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stall && wfi_req && deep_sel && !irq_pend && !dbg_wake)
      |=> (!sys_clk_en && pll_pd_req && flash_pd_req));

  p_nap_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && sys_clk_en && (irq_pend || dbg_wake)) |=> !core_stall);

  p_lock_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_en) |-> ($past(pll_locked) && !$past(pll_pd_req)));

  p_resume_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_stall) |-> (sys_clk_en && core_clk_en));

endmodule

bind sleep_ctrl_top sleep_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wfi_req      (wfi_req),
  .sev_req      (sev_req),
  .deep_sel     (deep_sel),
  .ext_evt      (ext_evt),
  .irq_pend     (irq_pend),
  .dbg_wake     (dbg_wake),
  .pll_locked   (pll_locked),
  .core_clk_en  (core_clk_en),
  .sys_clk_en   (sys_clk_en),
  .pll_pd_req   (pll_pd_req),
  .flash_pd_req (flash_pd_req),
  .core_stall   (core_stall),
  .evt_q        (evt_q),
  .wfe_skip     (wfe_skip)
);

// File: tb/sleep_ctrl_top_tb_top.sv
module sleep_ctrl_top_tb_top;

  localparam int unsigned FW = 4;
  // Output pattern {core_clk_en, sys_clk_en, pll_pd_req, flash_pd_req, core_stall}
  localparam logic [4:0] O_RUN = 5'b11000;
  localparam logic [4:0] O_NAP = 5'b01001;
  localparam logic [4:0] O_DP  = 5'b00111;
  localparam logic [4:0] O_RS  = 5'b00001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 0, wfe_req = 0, sev_req = 0, deep_sel = 0, ext_evt = 0;
  logic irq_pend = 0, dbg_wake = 0, pll_locked = 1;
  logic core_clk_en, sys_clk_en, pll_pd_req, flash_pd_req, core_stall;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sleep_ctrl_top #(.FLASH_WAKE_CYC(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .sev_req(sev_req), .deep_sel(deep_sel), .ext_evt(ext_evt),
    .irq_pend(irq_pend), .dbg_wake(dbg_wake), .pll_locked(pll_locked),
    .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
    .pll_pd_req(pll_pd_req), .flash_pd_req(flash_pd_req), .core_stall(core_stall)
  );

  function automatic logic [4:0] outs();
    return {core_clk_en, sys_clk_en, pll_pd_req, flash_pd_req, core_stall};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [4:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, outs(), exp);
    end
  endtask

  task automatic do_wfi(); wfi_req = 1; step(); wfi_req = 0; endtask
  task automatic do_wfe(); wfe_req = 1; step(); wfe_req = 0; endtask
  task automatic do_irq(); irq_pend = 1; step(); irq_pend = 0; endtask

  task automatic t_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
    chk("R1 run pattern after reset", O_RUN);
  endtask

  task automatic t_wfe_flow();
    do_wfe();  chk("R1 R3 flag clear after reset, wfe sleeps", O_NAP);
    ext_evt = 1; step(); ext_evt = 0;
    chk("R3 event ends wfe sleep", O_RUN);
    do_wfe();  chk("R12 wfe exit consumed flag, sleeps again", O_NAP);
    dbg_wake = 1; step(); dbg_wake = 0;
    chk("R8 debug wake ends wfe sleep", O_RUN);
  endtask

  task automatic t_sev_skip();
    sev_req = 1; step(); sev_req = 0; step(); step();
    do_wfe();  chk("R5 send-event makes wfe fall through", O_RUN);
    do_wfe();  chk("R4 fall-through cleared flag", O_NAP);
    do_irq();  chk("R8 interrupt ends wfe sleep", O_RUN);
    ext_evt = 1; step(); ext_evt = 0;
    do_wfe();  chk("R5 external event makes wfe fall through", O_RUN);
  endtask

  task automatic t_wfi_nap();
    deep_sel = 0;
    do_wfi();  chk("R2 R6 wfi nap gates only core clock", O_NAP);
    step(); step(); step();
    chk("R2 nap holds without wake", O_NAP);
    ext_evt = 1; step(); ext_evt = 0; step();
    chk("R2 event does not end wfi sleep", O_NAP);
    do_wfi(); do_wfe(); step();
    chk("R11 waits while stalled ignored", O_NAP);
    do_irq();  chk("R8 interrupt ends wfi nap", O_RUN);
    do_wfe();  chk("R11 R12 flag kept across wfi exit and stalled wfe", O_RUN);
  endtask

  task automatic t_debug_spurious();
    do_wfi();
    dbg_wake = 1; step(); dbg_wake = 0;
    chk("R8 debug wake ends wfi sleep", O_RUN);
    do_wfi();  chk("R8 wfi sleeps again after spurious wake", O_NAP);
    do_irq();  chk("R8 interrupt wake", O_RUN);
    do_wfe();  chk("R12 debug/interrupt set flag", O_RUN);
  endtask

  task automatic t_deep_late_lock();
    deep_sel = 1;
    do_wfi();  chk("R7 deep sleep pattern", O_DP);
    pll_locked = 0; step(); step(); step();
    chk("R7 deep held", O_DP);
    do_irq();  chk("R9 power restored first, clocks still gated", O_RS);
    repeat (FW + 6) step();
    chk("R9 waits for PLL lock", O_RS);
    pll_locked = 1; step();
    chk("R9 resumes after lock", O_RUN);
    do_wfe();
  endtask

  task automatic t_deep_flash_count();
    deep_sel = 1;
    do_wfi();  chk("R7 deep sleep pattern again", O_DP);
    dbg_wake = 1; step(); dbg_wake = 0;
    chk("R8 R9 debug wake starts restore", O_RS);
    repeat (FW) step();
    chk("R9 flash settling window", O_RS);
    step();
    chk("R9 resumes after flash window", O_RUN);
    deep_sel = 0;
    do_wfe();
  endtask

  task automatic t_wake_same_cycle();
    irq_pend = 1; wfi_req = 1; step(); wfi_req = 0;
    chk("R10 brief sleep with wake already active", O_NAP);
    step();
    chk("R10 back to run next cycle", O_RUN);
    irq_pend = 0;
    do_wfe();  chk("R12 interrupt set flag", O_RUN);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_wfe_flow();
    t_sev_skip();
    t_wfi_nap();
    t_debug_spurious();
    t_deep_late_lock();
    t_deep_flash_count();
    t_wake_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule